// File: doc/BRIEF.md
# Masked Packed Unsigned Multiply-High Unit

This block is a pipelined SIMD datapath. It splits two source vectors into unsigned 16-bit lanes and multiplies each pair of lanes into a full 32-bit product. It keeps only the upper half of each product as the lane result. A write mask can then replace or clear individual result lanes. The destination bits above the selected vector length are either kept from the previous destination value or forced to zero, and the encoding mode decides which.

The surrounding execution pipe presents both sources, the previous destination contents, the mask controls, a vector-length code and an encoding-mode code, with `in_valid` high for one cycle. The finished destination vector appears two clock edges later, with `out_valid` high. A new operation can be issued on every cycle. The unit produces no flags and raises no exceptions.

Top module: `mulhi_unit`

## Requirements
- R1: Each active result lane j (bits [16j+15:16j]) equals bits [31:16] of the unsigned 32-bit product of the matching lanes of `src_a` and `src_b`, unless the mask rules below apply.
- R2: `vl_sel` selects the active lane count: 0 selects 4 lanes (64 bits), 1 selects 8 lanes (128 bits), 2 selects 16 lanes (256 bits) and 3 selects 32 lanes (512 bits).
- R3: When masking is in force (`enc_mode`=2 and `mask_en`=1), an active lane whose `lane_mask` bit is 1 receives its product high half.
- R4: When masking is in force and `zero_mode`=0, an active lane whose mask bit is 0 keeps its `old_dst` value.
- R5: When masking is in force and `zero_mode`=1, an active lane whose mask bit is 0 is cleared to zero.
- R6: With `mask_en`=0 in the masked encoding, every active lane is written whatever the mask bits hold.
- R7: Mask bits at positions at or above the active lane count have no effect on the result.
- R8: In the legacy encoding (`enc_mode`=0), destination bits at or above the active vector length are copied from `old_dst`.
- R9: In the vector encoding (`enc_mode`=1), the masked encoding (`enc_mode`=2) and the reserved code 3, which acts as the vector encoding, destination bits at or above the active vector length are zero.
- R10: An operation offered with `in_valid` before clock edge k appears on `out_data` with `out_valid` high after edge k+1. Back-to-back operations come out on back-to-back cycles.
- R11: A synchronous reset drops `out_valid` at the next edge, and this discards operations that are in flight. `out_data` holds its value on cycles without a result.
- R12: Outside the masked encoding, `mask_en` and `lane_mask` are ignored and every active lane is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered this cycle |
| src_a | input | DATA_W (512) | First packed source |
| src_b | input | DATA_W (512) | Second packed source |
| old_dst | input | DATA_W (512) | Previous destination contents |
| lane_mask | input | MAX_LANES (32) | Per-lane write mask |
| mask_en | input | 1 | Apply the write mask (masked encoding only) |
| zero_mode | input | 1 | 1: masked-off lanes are cleared, 0: they keep the old value |
| vl_sel | input | 2 | Vector length code |
| enc_mode | input | 2 | 0 legacy, 1 vector, 2 masked, 3 treated as vector |
| out_valid | output | 1 | Result valid |
| out_data | output | DATA_W (512) | New destination vector |

## Verification
On every cycle, the embedded properties check the valid pipeline timing, the clearing of masked-off lanes in zeroing mode and their retention in merging mode, the zeroing or preservation of lanes above the active length, and the match between written lanes and the registered multiplier outputs. The bench scenarios cover the points that need a full reference: that the multiplier high half is arithmetically correct for extreme operands, that every vector-length code maps to the right lane count, that out-of-range mask bits and masks given in non-masked encodings leave the result unchanged, and that a reset issued mid-stream discards operations in flight.

// File: rtl/mulhi_pkg.sv
package mulhi_pkg;

    typedef enum logic [1:0] {
        ENC_LEGACY = 2'd0,
        ENC_VECTOR = 2'd1,
        ENC_MASKED = 2'd2,
        ENC_RSVD   = 2'd3
    } enc_mode_e;

    // Active lane count for a vector-length code, limited to the lanes built.
    function automatic int unsigned lanes_for(input logic [1:0] vl, input int unsigned max_lanes);
        int unsigned n;
        n = 32'd4 << vl;
        return (n > max_lanes) ? max_lanes : n;
    endfunction

endpackage

// File: rtl/mulhi_lane_mul.sv
module mulhi_lane_mul #(
    parameter int LANE_W = 16
) (
    input  logic              clk,
    input  logic              en,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] hi
);
    localparam int PROD_W = 2 * LANE_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = PROD_W'(a) * PROD_W'(b);
    end

    always_ff @(posedge clk) begin
        if (en) begin
            hi <= prod[PROD_W-1:LANE_W];
        end
    end
endmodule

// File: rtl/mulhi_lane_merge.sv
module mulhi_lane_merge #(
    parameter int LANE_W = 16
) (
    input  logic [LANE_W-1:0] prod_hi,
    input  logic [LANE_W-1:0] old_val,
    input  logic              active,
    input  logic              write_en,
    input  logic              zero_mode,
    input  logic              keep_upper,
    output logic [LANE_W-1:0] lane_out
);
    always_comb begin
        if (!active) begin
            lane_out = keep_upper ? old_val : '0;
        end else if (write_en) begin
            lane_out = prod_hi;
        end else begin
            lane_out = zero_mode ? '0 : old_val;
        end
    end
endmodule

// File: rtl/mulhi_unit.sv
module mulhi_unit
    import mulhi_pkg::*;
#(
    parameter int LANE_W    = 16,
    parameter int MAX_LANES = 32,
    localparam int DATA_W   = LANE_W * MAX_LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] old_dst,
    input  logic [MAX_LANES-1:0] lane_mask,
    input  logic              mask_en,
    input  logic              zero_mode,
    input  logic [1:0]        vl_sel,
    input  logic [1:0]        enc_mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    // Stage 1: products and captured controls.
    logic                 s1_valid;
    logic [DATA_W-1:0]    s1_old;
    logic [MAX_LANES-1:0] s1_mask;
    logic                 s1_masking;
    logic                 s1_zero;
    logic [1:0]           s1_vl;
    enc_mode_e            s1_enc;
    logic [DATA_W-1:0]    s1_prod;

    // Stage 2 inputs computed from stage 1.
    int unsigned          s1_lanes;
    logic [MAX_LANES-1:0] lane_act;
    logic [MAX_LANES-1:0] lane_wr;
    logic                 keep_upper;
    logic [DATA_W-1:0]    merged;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            s1_old     <= old_dst;
            s1_mask    <= lane_mask;
            s1_masking <= mask_en && (enc_mode_e'(enc_mode) == ENC_MASKED);
            s1_zero    <= zero_mode;
            s1_vl      <= vl_sel;
            s1_enc     <= enc_mode_e'(enc_mode);
        end
    end

    always_comb begin
        s1_lanes   = lanes_for(s1_vl, MAX_LANES);
        keep_upper = (s1_enc == ENC_LEGACY);
    end

    for (genvar gj = 0; gj < MAX_LANES; gj++) begin : g_lane
        mulhi_lane_mul #(.LANE_W(LANE_W)) u_mul (
            .clk (clk),
            .en  (in_valid),
            .a   (src_a[gj*LANE_W +: LANE_W]),
            .b   (src_b[gj*LANE_W +: LANE_W]),
            .hi  (s1_prod[gj*LANE_W +: LANE_W])
        );

        assign lane_act[gj] = (32'(gj) < s1_lanes);
        assign lane_wr[gj]  = !s1_masking || s1_mask[gj];

        mulhi_lane_merge #(.LANE_W(LANE_W)) u_merge (
            .prod_hi    (s1_prod[gj*LANE_W +: LANE_W]),
            .old_val    (s1_old[gj*LANE_W +: LANE_W]),
            .active     (lane_act[gj]),
            .write_en   (lane_wr[gj]),
            .zero_mode  (s1_zero),
            .keep_upper (keep_upper),
            .lane_out   (merged[gj*LANE_W +: LANE_W])
        );

        // Lane checks at the output register.
        p_zero_r5: assert property (@(posedge clk) disable iff (rst)
            s1_valid && s1_masking && s1_zero && !s1_mask[gj] && lane_act[gj]
            |=> out_data[gj*LANE_W +: LANE_W] == '0);

        p_merge_keep_r4: assert property (@(posedge clk) disable iff (rst)
            s1_valid && s1_masking && !s1_zero && !s1_mask[gj] && lane_act[gj]
            |=> out_data[gj*LANE_W +: LANE_W] == $past(s1_old[gj*LANE_W +: LANE_W]));

        p_written_r3: assert property (@(posedge clk) disable iff (rst)
            s1_valid && lane_act[gj] && (!s1_masking || s1_mask[gj])
            |=> out_data[gj*LANE_W +: LANE_W] == $past(s1_prod[gj*LANE_W +: LANE_W]));

        p_upper_clear_r9: assert property (@(posedge clk) disable iff (rst)
            s1_valid && (s1_enc != ENC_LEGACY) && !lane_act[gj]
            |=> out_data[gj*LANE_W +: LANE_W] == '0);

        p_upper_keep_r8: assert property (@(posedge clk) disable iff (rst)
            s1_valid && (s1_enc == ENC_LEGACY) && !lane_act[gj]
            |=> out_data[gj*LANE_W +: LANE_W] == $past(s1_old[gj*LANE_W +: LANE_W]));
    end

    // Stage 2: output register.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= s1_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (s1_valid) begin
            out_data <= merged;
        end
    end

    p_fill_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1_valid);

    p_drain_r10: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid);

    p_bubble_r10: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> !out_valid);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> $stable(out_data));

endmodule

// File: tb/tb_mulhi_unit.sv
`timescale 1ns/1ps
module tb_mulhi_unit;
    localparam int LW = 16;
    localparam int NL = 32;
    localparam int DW = LW * NL;

    typedef struct {
        logic          v;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW-1:0] old;
        logic [NL-1:0] mask;
        logic          men;
        logic          zm;
        logic [1:0]    vl;
        logic [1:0]    enc;
    } op_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] src_a = '0, src_b = '0, old_dst = '0;
    logic [NL-1:0] lane_mask = '0;
    logic          mask_en = 1'b0, zero_mode = 1'b0;
    logic [1:0]    vl_sel = '0, enc_mode = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int n_checks = 0;
    int n_errors = 0;

    logic          pv [2];
    logic [DW-1:0] pe [2];
    string         pt [2];

    always #4 clk = ~clk;

    mulhi_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .old_dst(old_dst),
        .lane_mask(lane_mask), .mask_en(mask_en), .zero_mode(zero_mode),
        .vl_sel(vl_sel), .enc_mode(enc_mode),
        .out_valid(out_valid), .out_data(out_data)
    );

    // Reference built from the requirements.
    function automatic logic [DW-1:0] model(input op_t o);
        logic [DW-1:0] r;
        int nl;
        logic masking;
        nl = 4 << o.vl;
        if (nl > NL) nl = NL;
        masking = o.men && (o.enc == 2'd2);
        for (int j = 0; j < NL; j++) begin
            logic [31:0] p;
            p = 32'(o.a[j*LW +: LW]) * 32'(o.b[j*LW +: LW]);
            if (j >= nl)
                r[j*LW +: LW] = (o.enc == 2'd0) ? o.old[j*LW +: LW] : 16'h0;
            else if (!masking || o.mask[j])
                r[j*LW +: LW] = p[31:16];
            else
                r[j*LW +: LW] = o.zm ? 16'h0 : o.old[j*LW +: LW];
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] rnd_vec();
        logic [DW-1:0] r;
        for (int k = 0; k < DW/32; k++) begin
            r[k*32 +: 32] = $urandom();
            if (($urandom() % 8) == 0) r[k*32 +: 16] = 16'hFFFF;
        end
        return r;
    endfunction

    function automatic op_t idle_op();
        op_t o;
        o.v = 1'b0; o.a = '0; o.b = '0; o.old = '0; o.mask = '0;
        o.men = 1'b0; o.zm = 1'b0; o.vl = 2'd0; o.enc = 2'd0;
        return o;
    endfunction

    task automatic check_out();
        n_checks++;
        if (out_valid !== pv[1]) begin
            n_errors++;
            $display("FAIL R10 out_valid actual=%b expected=%b", out_valid, pv[1]);
        end
        if (pv[1]) begin
            n_checks++;
            if (out_data !== pe[1]) begin
                n_errors++;
                $display("FAIL %s out_data actual=%h expected=%h", pt[1], out_data, pe[1]);
            end
        end
    endtask

    task automatic step(input op_t o, input string tag);
        @(negedge clk);
        check_out();
        pv[1] = pv[0]; pe[1] = pe[0]; pt[1] = pt[0];
        pv[0] = o.v;   pe[0] = model(o); pt[0] = tag;
        in_valid  = o.v;
        src_a     = o.a;
        src_b     = o.b;
        old_dst   = o.old;
        lane_mask = o.mask;
        mask_en   = o.men;
        zero_mode = o.zm;
        vl_sel    = o.vl;
        enc_mode  = o.enc;
    endtask

    task automatic flush();
        for (int k = 0; k < 3; k++) step(idle_op(), "R10");
    endtask

    task automatic run(input op_t o, input string tag);
        o.v = 1'b1;
        step(o, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        op_t o;
        logic [DW-1:0] held;
        void'($urandom(32'h1c0ffee5));
        pv[0] = 1'b0; pv[1] = 1'b0; pe[0] = '0; pe[1] = '0; pt[0] = ""; pt[1] = "";

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_errors++;
            $display("FAIL R11 reset out_valid actual=%b expected=0", out_valid);
        end

        // R1: extreme operands in the vector encoding, full width.
        o = idle_op(); o.enc = 2'd1; o.vl = 2'd3;
        o.a = {NL{16'hFFFF}}; o.b = {NL{16'hFFFF}};
        run(o, "R1");
        o.a = {NL{16'h8000}}; o.b = {NL{16'h0002}};
        run(o, "R1");
        o.a = {NL{16'h0001}}; o.b = {NL{16'hFFFF}};
        run(o, "R1");
        flush();
        n_checks++;
        if (out_data[15:0] !== 16'h0000) begin
            n_errors++;
            $display("FAIL R1 small product lane actual=%h expected=0000", out_data[15:0]);
        end

        // R2 / R9: each length code in the vector encoding with an all-ones old value.
        for (int v = 0; v < 4; v++) begin
            o = idle_op(); o.enc = 2'd1; o.vl = v[1:0];
            o.a = rnd_vec(); o.b = rnd_vec(); o.old = '1;
            run(o, "R2");
        end
        o.enc = 2'd3; o.vl = 2'd1;
        run(o, "R9");
        // R8: legacy encoding at 64 and 128 bits keeps the upper bits.
        for (int v = 0; v < 2; v++) begin
            o = idle_op(); o.enc = 2'd0; o.vl = v[1:0];
            o.a = rnd_vec(); o.b = rnd_vec(); o.old = rnd_vec();
            run(o, "R8");
        end
        // R9: masked encoding clears above the length.
        o = idle_op(); o.enc = 2'd2; o.vl = 2'd1; o.men = 1'b1; o.mask = 32'hFFFF_FFA5;
        o.a = rnd_vec(); o.b = rnd_vec(); o.old = '1;
        run(o, "R9");
        // R3 / R4: merging mask.
        o = idle_op(); o.enc = 2'd2; o.vl = 2'd3; o.men = 1'b1; o.zm = 1'b0;
        o.mask = 32'h5A5A_0FF0; o.a = rnd_vec(); o.b = rnd_vec(); o.old = rnd_vec();
        run(o, "R4");
        // R5: zeroing mask.
        o.zm = 1'b1; o.mask = 32'hC3C3_1234; o.old = '1;
        run(o, "R5");
        // R3: all-ones mask writes every lane.
        o.zm = 1'b1; o.mask = '1;
        run(o, "R3");
        // R6: masking disabled with an all-zero mask.
        o.men = 1'b0; o.mask = '0;
        run(o, "R6");
        // R12: mask given outside the masked encoding.
        o.enc = 2'd1; o.men = 1'b1; o.mask = '0; o.zm = 1'b1;
        run(o, "R12");
        o.enc = 2'd0; o.vl = 2'd1; o.zm = 1'b0;
        run(o, "R12");
        flush();

        // R7: upper mask bits set versus clear give the same result.
        o = idle_op(); o.enc = 2'd2; o.vl = 2'd0; o.men = 1'b1; o.zm = 1'b1;
        o.a = rnd_vec(); o.b = rnd_vec(); o.old = rnd_vec(); o.mask = 32'h0000_0005;
        run(o, "R7");
        flush();
        held = out_data;
        o.mask = 32'hFFFF_FFF5;
        run(o, "R7");
        flush();
        n_checks++;
        if (out_data !== held) begin
            n_errors++;
            $display("FAIL R7 upper mask bits actual=%h expected=%h", out_data, held);
        end

        // R11: out_data holds while idle.
        held = out_data;
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_data !== held) begin
            n_errors++;
            $display("FAIL R11 hold actual=%h expected=%h", out_data, held);
        end

        // R11: reset while operations are in flight.
        o = idle_op(); o.enc = 2'd1; o.vl = 2'd2; o.a = rnd_vec(); o.b = rnd_vec();
        run(o, "R11");
        run(o, "R11");
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_errors++;
            $display("FAIL R11 in-flight out_valid actual=%b expected=0", out_valid);
        end
        @(negedge clk);
        rst = 1'b0;
        pv[0] = 1'b0; pv[1] = 1'b0;

        // Random mix, back-to-back with occasional bubbles (R10).
        for (int n = 0; n < 3000; n++) begin
            o.v    = (($urandom() % 5) != 0);
            o.a    = rnd_vec();
            o.b    = rnd_vec();
            o.old  = rnd_vec();
            o.mask = $urandom();
            o.men  = $urandom() % 2;
            o.zm   = $urandom() % 2;
            o.vl   = $urandom() % 4;
            o.enc  = $urandom() % 4;
            step(o, "R10");
        end
        flush();

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule